// File: doc/BRIEF.md
# Prescaled timer/counter channel with external event input

This block is one timer/counter channel of the kind found beside a small microcontroller core. It holds a count in two bus-writable bytes, a high byte and a low byte. It advances that count in one of two ways. In timer mode it steps on ticks of an internal time base. In counter mode it steps on falling edges seen on an external pin.

The time base divides the system clock by twelve by default, or by four when the fast select input is high. The external pin is sampled once per time-base tick. An edge is recognised only when a high sample is followed by a low sample, and the count moves one tick after that.

Three count layouts are available: a 13-bit counter, a full 16-bit counter, and an 8-bit counter that reloads from the high byte. Each sets a sticky overflow flag when it wraps. Software or a hardware acknowledge clears the flag. A run bit and an optional gate level together decide whether counting is allowed.

Top module: `tmr_chan`

## Requirements
- R1: While reset is asserted and after its release, cnt_hi, cnt_lo and ovf_flag are 0. The prescaler starts from 0 and the pin sample history is all zeros.
- R2: In timer mode (cnt_sel=0) with fast=0, an enabled count advances by one on every 12th clock. The first advance comes on the 12th rising edge after reset release.
- R3: With fast=1 the time-base tick comes every 4 clocks. When fast is raised, a prescaler already at or past 3 ticks on the next edge and restarts from 0.
- R4: In counter mode (cnt_sel=1), ext_pin is sampled on each tick. A sample of 0 that follows a sample of 1 marks an edge, and the count advances on the following tick. A pin that toggles every tick (24 clocks per period at the slow rate) is counted once per period.
- R5: The count advances only when run=1 and either gate_en=0 or gate_in=1. Otherwise the count bytes hold.
- R6: With mode=0, {cnt_hi, cnt_lo[4:0]} is a 13-bit counter and cnt_lo[7:5] never changes by counting. The step from 1FFFh to 0 sets ovf_flag.
- R7: With mode=1, {cnt_hi, cnt_lo} is a 16-bit counter. The step from FFFFh to 0 sets ovf_flag.
- R8: With mode=2, only cnt_lo counts. A step from FFh loads cnt_lo from cnt_hi and sets ovf_flag. cnt_hi is never changed by counting.
- R9: ovf_flag stays set until a clock with ovf_clr=1 or ovf_ack=1 clears it. If an overflow falls in the same clock as a clear, the flag ends up set.
- R10: wr_hi loads cnt_hi from wr_data and wr_lo loads cnt_lo from wr_data. In any clock with a write, the whole count step of that clock is dropped, including its overflow.
- R11: With mode=3 the count bytes do not change except by writes, and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_sel | input | 1 | 0 = time-base ticks, 1 = external pin edges |
| mode | input | 2 | Count layout: 0 = 13-bit, 1 = 16-bit, 2 = 8-bit reload, 3 = hold |
| run | input | 1 | Run enable |
| gate_en | input | 1 | When 1, counting also needs gate_in high |
| gate_in | input | 1 | External gate level |
| fast | input | 1 | Time base: 0 = clock/12, 1 = clock/4 |
| ext_pin | input | 1 | External event input |
| wr_hi | input | 1 | Write strobe for the high byte |
| wr_lo | input | 1 | Write strobe for the low byte |
| wr_data | input | 8 | Write data |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| ovf_ack | input | 1 | Hardware acknowledge pulse that clears the flag |
| cnt_hi | output | 8 | High count byte |
| cnt_lo | output | 8 | Low count byte |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two collisions are provoked on purpose. The first is an overflow landing in the same clock as a flag clear. The bench holds ovf_clr high while the 8-bit reload mode wraps every few ticks, and expects the flag to read set after the wrap and clear one clock later. The second is a bus write landing on a tick that would have stepped the count. Random writes on many tick clocks must show the written byte, an untouched other byte, and no overflow from the dropped step.

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_sel,
  input  logic [1:0] mode,
  input  logic       run,
  input  logic       gate_en,
  input  logic       gate_in,
  input  logic       fast,
  input  logic       ext_pin,
  input  logic       wr_hi,
  input  logic       wr_lo,
  input  logic [7:0] wr_data,
  input  logic       ovf_clr,
  input  logic       ovf_ack,
  output logic [7:0] cnt_hi,
  output logic [7:0] cnt_lo,
  output logic       ovf_flag
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam logic [PW-1:0] LIM_SLOW = PW'(DIV_SLOW - 1);
  localparam logic [PW-1:0] LIM_FAST = PW'(DIV_FAST - 1);

  logic [PW-1:0] ps;
  logic          smp_new, smp_old;
  logic [7:0]    nx_hi, nx_lo;
  logic          wrap;

  wire [PW-1:0] lim     = fast ? LIM_FAST : LIM_SLOW;
  wire          tick    = ps >= lim;
  wire          fall    = smp_old & ~smp_new;
  wire          gate_ok = run & (~gate_en | gate_in);
  wire          step    = tick & gate_ok & (cnt_sel ? fall : 1'b1);
  wire          wr_any  = wr_hi | wr_lo;
  wire          adv     = step & ~wr_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps      <= '0;
      smp_new <= 1'b0;
      smp_old <= 1'b0;
    end else begin
      ps <= tick ? '0 : ps + 1'b1;
      if (tick) begin
        smp_new <= ext_pin;
        smp_old <= smp_new;
      end
    end
  end

  always_comb begin
    nx_hi = cnt_hi;
    nx_lo = cnt_lo;
    wrap  = 1'b0;
    case (mode)
      2'd0: begin
        nx_lo = {cnt_lo[7:5], cnt_lo[4:0] + 5'd1};
        if (cnt_lo[4:0] == 5'h1F) begin
          nx_hi = cnt_hi + 8'd1;
          wrap  = (cnt_hi == 8'hFF);
        end
      end
      2'd1: {wrap, nx_hi, nx_lo} = {1'b0, cnt_hi, cnt_lo} + 17'd1;
      2'd2: begin
        if (cnt_lo == 8'hFF) begin
          nx_lo = cnt_hi;
          wrap  = 1'b1;
        end else begin
          nx_lo = cnt_lo + 8'd1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_hi   <= '0;
      cnt_lo   <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_hi) cnt_hi <= wr_data;
      if (wr_lo) cnt_lo <= wr_data;
      if (adv) begin
        cnt_hi <= nx_hi;
        cnt_lo <= nx_lo;
      end
      if (adv & wrap) ovf_flag <= 1'b1;
      else if (ovf_clr | ovf_ack) ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       run,
  input logic       wr_hi,
  input logic       wr_lo,
  input logic [7:0] wr_data,
  input logic       ovf_clr,
  input logic       ovf_ack,
  input logic [7:0] cnt_hi,
  input logic [7:0] cnt_lo,
  input logic       ovf_flag
);
  a_r1_reset_clear: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (cnt_hi == 8'd0 && cnt_lo == 8'd0 && !ovf_flag));

  a_r5_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_hi && !wr_lo) |=> ($stable(cnt_hi) && $stable(cnt_lo)));

  a_r6_upper_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !wr_lo) |=> $stable(cnt_lo[7:5]));

  a_r8_reload_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !wr_hi) |=> $stable(cnt_hi));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr && !ovf_ack) |=> ovf_flag);

  a_r10_write_hi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt_hi == $past(wr_data)));

  a_r10_write_lo_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_lo == $past(wr_data)));

  a_r11_hold_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !wr_hi && !wr_lo) |=> ($stable(cnt_hi) && $stable(cnt_lo)));
endmodule

bind tmr_chan tmr_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .run(run),
  .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
  .ovf_clr(ovf_clr), .ovf_ack(ovf_ack),
  .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .ovf_flag(ovf_flag)
);

// File: tb/tb_tmr_chan.sv
module tb_tmr_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_sel = 0, run = 0, gate_en = 0, gate_in = 0, fast = 0, ext_pin = 0;
  logic [1:0] mode = 2'd1;
  logic wr_hi = 0, wr_lo = 0, ovf_clr = 0, ovf_ack = 0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] cnt_hi, cnt_lo;
  logic ovf_flag;

  always #5 clk = ~clk;

  tmr_chan dut (
    .clk(clk), .rst_n(rst_n), .cnt_sel(cnt_sel), .mode(mode), .run(run),
    .gate_en(gate_en), .gate_in(gate_in), .fast(fast), .ext_pin(ext_pin),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .ovf_clr(ovf_clr), .ovf_ack(ovf_ack),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .ovf_flag(ovf_flag)
  );

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R1";

  int m_ps;
  bit m_sn, m_so, m_ov;
  logic [7:0] m_hi, m_lo;

  function automatic logic [16:0] next_count(logic [1:0] md, logic [7:0] h, logic [7:0] l);
    logic [16:0] r;
    r = {1'b0, h, l};
    case (md)
      2'd0: begin
        r[7:0] = {l[7:5], l[4:0] + 5'd1};
        if (l[4:0] == 5'h1F) begin r[15:8] = h + 8'd1; r[16] = (h == 8'hFF); end
      end
      2'd1: r = {1'b0, h, l} + 17'd1;
      2'd2: if (l == 8'hFF) r = {1'b1, h, h}; else r[7:0] = l + 8'd1;
      default: ;
    endcase
    return r;
  endfunction

  task automatic model_update();
    int lim;
    bit tk, fall, ok, st;
    logic [16:0] n;
    lim  = fast ? 3 : 11;
    tk   = (m_ps >= lim);
    fall = m_so && !m_sn;
    ok   = run && (!gate_en || gate_in);
    st   = tk && ok && (cnt_sel ? fall : 1'b1);
    n    = next_count(mode, m_hi, m_lo);
    if (wr_hi) m_hi = wr_data;
    if (wr_lo) m_lo = wr_data;
    if (st && !wr_hi && !wr_lo) begin
      m_hi = n[15:8]; m_lo = n[7:0];
      if (n[16]) m_ov = 1;
      else if (ovf_clr || ovf_ack) m_ov = 0;
    end else if (ovf_clr || ovf_ack) m_ov = 0;
    if (tk) begin m_so = m_sn; m_sn = ext_pin; m_ps = 0; end
    else m_ps = m_ps + 1;
  endtask

  task automatic check_out();
    checks++;
    if ({ovf_flag, cnt_hi, cnt_lo} !== {m_ov, m_hi, m_lo}) begin
      failures++;
      $display("FAIL %s: got ovf=%0b hi=%02h lo=%02h expected ovf=%0b hi=%02h lo=%02h",
               tag, ovf_flag, cnt_hi, cnt_lo, m_ov, m_hi, m_lo);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      model_update();
      @(negedge clk);
      check_out();
      wr_hi = 0; wr_lo = 0; ovf_clr = 0; ovf_ack = 0;
    end
  endtask

  task automatic write_both(logic [7:0] h, logic [7:0] l);
    wr_hi = 1; wr_data = h; step();
    wr_lo = 1; wr_data = l; step();
  endtask

  task automatic mode_tag();
    if (cnt_sel) tag = "R4";
    else case (mode)
      2'd0: tag = "R6";
      2'd1: tag = "R7";
      2'd2: tag = "R8";
      default: tag = "R11";
    endcase
  endtask

  initial begin
    void'($urandom(32'd5150));
    m_ps = 0; m_sn = 0; m_so = 0; m_ov = 0; m_hi = 0; m_lo = 0;
    repeat (3) @(negedge clk);
    tag = "R1";
    check_out();
    rst_n = 1;
    // R1: state held at zero with run off
    step(3);

    // R2: slow time base, 16-bit count
    tag = "R2"; run = 1; mode = 2'd1;
    step(60);
    // R3: fast time base, switched while prescaler is past the fast limit
    tag = "R3"; fast = 1;
    step(41);
    fast = 0; step(30);

    // R4: external edges at the fastest recognisable rate, then slower
    tag = "R4"; cnt_sel = 1;
    for (int k = 0; k < 12; k++) begin ext_pin = ~ext_pin; step(12); end
    for (int k = 0; k < 8; k++) begin ext_pin = ~ext_pin; step(37); end
    ext_pin = 0; step(5); ext_pin = 1; step(3); ext_pin = 0; step(30);
    cnt_sel = 0;

    // R5: gating and run
    tag = "R5"; fast = 1; gate_en = 1; gate_in = 0; step(20);
    gate_in = 1; step(20);
    run = 0; step(20);
    run = 1; gate_en = 0; gate_in = 0; step(10);

    // R6: 13-bit wrap with upper low bits set
    tag = "R6"; mode = 2'd0; write_both(8'hFF, 8'hFC);
    step(30);
    ovf_clr = 1; step();
    // R7: 16-bit wrap
    tag = "R7"; mode = 2'd1; write_both(8'hFF, 8'hFD);
    step(20);
    ovf_ack = 1; step();
    // R8: reload
    tag = "R8"; mode = 2'd2; write_both(8'hF3, 8'hFC);
    step(80);
    // R9: clear held high while wraps keep arriving
    tag = "R9"; write_both(8'hFE, 8'hFE);
    for (int k = 0; k < 60; k++) begin ovf_clr = 1; step(); end
    step(20);
    for (int k = 0; k < 30; k++) begin ovf_ack = (k % 3 == 0); step(); end
    // R10: writes on every other clock
    tag = "R10"; mode = 2'd1; write_both(8'hFF, 8'hFF);
    for (int k = 0; k < 80; k++) begin
      wr_data = 8'($urandom);
      if (k % 2 == 0) begin wr_hi = (k % 4 == 0); wr_lo = (k % 4 != 0); end
      step();
    end
    // R11: hold mode
    tag = "R11"; mode = 2'd3; step(40);
    write_both(8'h12, 8'h34); step(20);

    // mixed random run
    for (int blk = 0; blk < 60; blk++) begin
      mode    = 2'($urandom);
      cnt_sel = ($urandom % 4) == 0;
      fast    = $urandom % 2;
      gate_en = ($urandom % 3) == 0;
      run     = ($urandom % 8) != 0;
      mode_tag();
      for (int k = 0; k < 50; k++) begin
        if ($urandom % 6 == 0) ext_pin = ~ext_pin;
        if ($urandom % 5 == 0) gate_in = ~gate_in;
        wr_data = ($urandom % 2) ? 8'hFF - 8'($urandom % 4) : 8'($urandom);
        wr_hi   = ($urandom % 20) == 0;
        wr_lo   = ($urandom % 20) == 0;
        ovf_clr = ($urandom % 25) == 0;
        ovf_ack = ($urandom % 25) == 0;
        step();
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule